// File: doc/BRIEF.md
# Segment identifier scrambler

This block turns a process context number and a 64-bit effective address into a scrambled virtual segment identifier. The context and the segment-number bits of the address are joined into a proto-identifier. That value is multiplied by a fixed prime. The product is then reduced modulo 2^n − 1 with a fold-and-add followed by a one-step correction, so no divider is needed. Two segment sizes are supported: 256 MB segments with n = 37, and 1 TB segments with n = 25.

In kernel mode the context does not come from the context input. It is taken from the top nibble of the address. Addresses that fall outside the supported span, kernel addresses in a non-kernel region and out-of-range user contexts all give identifier 0.

Requests enter on a valid strobe and may arrive every cycle. The result leaves a fixed four cycles later. The multiplier takes three pipeline stages and the output register holds the reduced value.

Top module: `seg_id_scrambler`

## Requirements
- R1: A request sampled with `in_valid` high gives exactly one `out_valid` pulse 4 clock cycles later. Requests may be issued on back-to-back cycles, and results come out in issue order.
- R2: With `in_seg1t` = 0, the proto-identifier is {context, ea[45:28]} (37 bits). `out_vsid` = proto × 12538073 mod (2^37 − 1).
- R3: With `in_seg1t` = 1, the proto-identifier is {context, ea[45:40]} (25 bits). `out_vsid`[24:0] = proto × 12538073 mod (2^25 − 1), and `out_vsid`[36:25] = 0.
- R4: The result never equals the modulus. A proto-identifier whose bits are all ones gives 0.
- R5: With `in_kernel` = 1 and ea[63:60] in 0xC..0xF, the context is 0x7FFFC + (ea[63:60] − 0xC). `in_context` has no effect.
- R6: With `in_kernel` = 1 and ea[63:60] below 0xC, the result is 0.
- R7: If any of ea[59:46] is set, the result is 0 in either segment size and either mode.
- R8: In user mode (`in_kernel` = 0), a context above 0x7FFFB gives 0. In user mode ea[63:60] has no effect on the result.
- R9: While reset is asserted, `out_valid` and `out_vsid` are 0.
- R10: `out_vsid` keeps its last value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| in_valid | input | 1 | Request strobe |
| in_kernel | input | 1 | 1: derive the context from ea[63:60] |
| in_seg1t | input | 1 | 0: 256 MB segments, 1: 1 TB segments |
| in_context | input | 19 | User context number |
| in_ea | input | 64 | Effective address |
| out_valid | output | 1 | Result strobe, 4 cycles after the request |
| out_vsid | output | 37 | Scrambled segment identifier |

## Verification
Random user and kernel requests in both segment sizes are compared with a plain (proto × multiplier) % (2^n − 1) model. Because the model does not use folding, an error in the fold or the correction shows up as a mismatch. Directed all-ones proto-identifiers in each size show whether the correction step reaches exactly 0. Boundary contexts (0x7FFFB against 0x7FFFC) and single set bits at ea[46] and ea[59] separate the reject rules from the arithmetic. Kernel requests with a random `in_context`, and user requests that differ only in the top nibble, show which inputs really have no effect. Bubbles in the request stream expose latency slips and an output that changes without `out_valid`.

// File: rtl/seg_scr_pkg.sv
package seg_scr_pkg;
  localparam int unsigned DEF_CTX_W     = 19;
  localparam int unsigned DEF_ESID_LO_W = 18;
  localparam int unsigned DEF_ESID_HI_W = 6;
  localparam int unsigned DEF_SHIFT_LO  = 28;
  localparam int unsigned DEF_SHIFT_HI  = 40;
  localparam int unsigned DEF_SPAN_LOG2 = 46;
  localparam int unsigned DEF_EA_W      = 64;
  localparam int unsigned DEF_MULT_W    = 24;
  localparam int unsigned DEF_MULT      = 12538073;
  localparam int unsigned DEF_SLICE_W   = 8;

  typedef enum logic {
    SEG_SMALL = 1'b0,
    SEG_LARGE = 1'b1
  } seg_size_e;
endpackage

// File: rtl/seg_scr_decode.sv
module seg_scr_decode #(
  parameter int unsigned CTX_W     = 19,
  parameter int unsigned ESID_LO_W = 18,
  parameter int unsigned ESID_HI_W = 6,
  parameter int unsigned SHIFT_LO  = 28,
  parameter int unsigned SHIFT_HI  = 40,
  parameter int unsigned SPAN_LOG2 = 46,
  parameter int unsigned EA_W      = 64
) (
  input  logic                          kernel,
  input  seg_scr_pkg::seg_size_e        seg_size,
  input  logic [CTX_W-1:0]              ctx,
  input  logic [EA_W-1:0]               ea,
  output logic [CTX_W+ESID_LO_W-1:0]    proto,
  output logic                          bad
);
  localparam int unsigned N_LO = CTX_W + ESID_LO_W;
  localparam int unsigned N_HI = CTX_W + ESID_HI_W;
  localparam logic [CTX_W-1:0] MAX_USER_CTX = CTX_W'((1 << CTX_W) - 5);

  logic [3:0]           nib;
  logic [CTX_W-1:0]     kctx;
  logic [CTX_W-1:0]     eff_ctx;
  logic                 span_bad;
  logic                 ctx_bad;
  logic [N_LO-1:0]      proto_raw;
  logic                 unused_ea_low;

  assign unused_ea_low = ^ea[SHIFT_LO-1:0];

  always_comb begin
    nib      = ea[EA_W-1 -: 4];
    kctx     = MAX_USER_CTX + CTX_W'(1) + CTX_W'(nib - 4'hC);
    eff_ctx  = kernel ? kctx : ctx;
    span_bad = |ea[EA_W-5:SPAN_LOG2];
    ctx_bad  = kernel ? (nib < 4'hC) : (ctx > MAX_USER_CTX);
    bad      = span_bad | ctx_bad;
    if (seg_size == seg_scr_pkg::SEG_LARGE)
      proto_raw = N_LO'({eff_ctx, ea[SHIFT_HI +: ESID_HI_W]});
    else
      proto_raw = {eff_ctx, ea[SHIFT_LO +: ESID_LO_W]};
    proto = bad ? '0 : proto_raw;
  end

  // R5: a kernel context accepted here always lies in the top four contexts
  always_comb begin
    if (kernel && !bad) begin
      a_r5_kernel_ctx: assert (eff_ctx[CTX_W-1:2] == '1 && eff_ctx[1:0] == nib[1:0])
        else $error("kernel context outside top four");
    end
  end

  // R3: large segments leave the upper proto bits clear
  always_comb begin
    if (seg_size == seg_scr_pkg::SEG_LARGE) begin
      a_r3_proto_narrow: assert (proto[N_LO-1:N_HI] == '0)
        else $error("large-segment proto too wide");
    end
  end
endmodule

// File: rtl/seg_scr_mult.sv
module seg_scr_mult #(
  parameter int unsigned A_W     = 37,
  parameter int unsigned MULT_W  = 24,
  parameter int unsigned MULT    = 12538073,
  parameter int unsigned SLICE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_v,
  input  logic [A_W-1:0]         in_a,
  input  seg_scr_pkg::seg_size_e in_tag,
  output logic                   out_v,
  output logic [A_W+MULT_W-1:0]  out_p,
  output seg_scr_pkg::seg_size_e out_tag
);
  localparam int unsigned P_W  = A_W + MULT_W;
  localparam int unsigned NSL  = MULT_W / SLICE_W;
  localparam int unsigned PP_W = A_W + SLICE_W;
  localparam logic [MULT_W-1:0] MULT_P = MULT_W'(MULT);

  // stage 1: one partial product per multiplier slice
  logic                    v1_q;
  seg_scr_pkg::seg_size_e  tag1_q;
  logic [PP_W-1:0]         pp_d [NSL];
  logic [PP_W-1:0]         pp_q [NSL];
  // stage 2: all slices but the top one summed
  logic                    v2_q;
  seg_scr_pkg::seg_size_e  tag2_q;
  logic [P_W-1:0]          part_d, part_q;
  logic [PP_W-1:0]         last_q;
  // stage 3: full product
  logic                    v3_q;
  seg_scr_pkg::seg_size_e  tag3_q;
  logic [P_W-1:0]          prod_d, prod_q;

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    assign pp_d[i] = PP_W'(in_a) * PP_W'(MULT_P[i*SLICE_W +: SLICE_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pp_q[i] <= '0;
      else if (in_v) pp_q[i] <= pp_d[i];
    end
  end

  always_comb begin
    part_d = '0;
    for (int i = 0; i < NSL - 1; i++)
      part_d = part_d + (P_W'(pp_q[i]) << (i * SLICE_W));
    prod_d = part_q + (P_W'(last_q) << ((NSL - 1) * SLICE_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_v;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1_q <= seg_scr_pkg::SEG_SMALL;
      tag2_q <= seg_scr_pkg::SEG_SMALL;
      tag3_q <= seg_scr_pkg::SEG_SMALL;
      part_q <= '0;
      last_q <= '0;
      prod_q <= '0;
    end else begin
      if (in_v) tag1_q <= in_tag;
      if (v1_q) begin
        tag2_q <= tag1_q;
        part_q <= part_d;
        last_q <= pp_q[NSL-1];
      end
      if (v2_q) begin
        tag3_q <= tag2_q;
        prod_q <= prod_d;
      end
    end
  end

  assign out_v   = v3_q;
  assign out_p   = prod_q;
  assign out_tag = tag3_q;

  // R2: the sliced pipeline yields the full product of the operand three cycles back
  a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
    v3_q |-> prod_q == P_W'($past(in_a, 3)) * P_W'(MULT_P))
    else $error("pipelined product mismatch");
endmodule

// File: rtl/seg_scr_fold.sv
module seg_scr_fold #(
  parameter int unsigned N   = 37,
  parameter int unsigned P_W = 61
) (
  input  logic [P_W-1:0] prod,
  output logic [N-1:0]   res
);
  localparam int unsigned XW = (((P_W - N) > N) ? (P_W - N) : N) + 1;

  logic [XW-1:0] x;
  logic [XW-1:0] xp1;
  logic [XW-1:0] carry;
  logic [XW-1:0] sum;

  always_comb begin
    x     = XW'(prod >> N) + XW'(prod[N-1:0]);
    xp1   = x + XW'(1);
    carry = xp1 >> N;
    sum   = x + carry;
    res   = sum[N-1:0];
  end
endmodule

// File: rtl/seg_id_scrambler.sv
module seg_id_scrambler #(
  parameter int unsigned CTX_W     = seg_scr_pkg::DEF_CTX_W,
  parameter int unsigned ESID_LO_W = seg_scr_pkg::DEF_ESID_LO_W,
  parameter int unsigned ESID_HI_W = seg_scr_pkg::DEF_ESID_HI_W,
  parameter int unsigned SHIFT_LO  = seg_scr_pkg::DEF_SHIFT_LO,
  parameter int unsigned SHIFT_HI  = seg_scr_pkg::DEF_SHIFT_HI,
  parameter int unsigned SPAN_LOG2 = seg_scr_pkg::DEF_SPAN_LOG2,
  parameter int unsigned EA_W      = seg_scr_pkg::DEF_EA_W,
  parameter int unsigned MULT_W    = seg_scr_pkg::DEF_MULT_W,
  parameter int unsigned MULT      = seg_scr_pkg::DEF_MULT,
  parameter int unsigned SLICE_W   = seg_scr_pkg::DEF_SLICE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_kernel,
  input  logic                       in_seg1t,
  input  logic [CTX_W-1:0]           in_context,
  input  logic [EA_W-1:0]            in_ea,
  output logic                       out_valid,
  output logic [CTX_W+ESID_LO_W-1:0] out_vsid
);
  localparam int unsigned N_LO = CTX_W + ESID_LO_W;
  localparam int unsigned N_HI = CTX_W + ESID_HI_W;
  localparam int unsigned P_W  = N_LO + MULT_W;
  localparam int unsigned LAT  = 4;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seg_scr_pkg::seg_size_e seg_size;
  logic [N_LO-1:0]        dec_proto;
  logic                   dec_bad;
  logic                   m_v;
  logic [P_W-1:0]         m_prod;
  seg_scr_pkg::seg_size_e m_tag;
  logic [N_LO-1:0]        res_lo;
  logic [N_HI-1:0]        res_hi;
  logic [N_LO-1:0]        vsid_d;
  logic                   out_valid_q;
  logic [N_LO-1:0]        out_vsid_q;
  seg_scr_pkg::seg_size_e out_tag_q;

  assign seg_size = in_seg1t ? seg_scr_pkg::SEG_LARGE : seg_scr_pkg::SEG_SMALL;

  seg_scr_decode #(
    .CTX_W(CTX_W), .ESID_LO_W(ESID_LO_W), .ESID_HI_W(ESID_HI_W),
    .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI), .SPAN_LOG2(SPAN_LOG2), .EA_W(EA_W)
  ) u_decode (
    .kernel(in_kernel), .seg_size(seg_size), .ctx(in_context), .ea(in_ea),
    .proto(dec_proto), .bad(dec_bad)
  );

  seg_scr_mult #(
    .A_W(N_LO), .MULT_W(MULT_W), .MULT(MULT), .SLICE_W(SLICE_W)
  ) u_mult (
    .clk(clk), .rst_n(rst_int_n), .in_v(in_valid), .in_a(dec_proto), .in_tag(seg_size),
    .out_v(m_v), .out_p(m_prod), .out_tag(m_tag)
  );

  seg_scr_fold #(.N(N_LO), .P_W(P_W)) u_fold_lo (.prod(m_prod), .res(res_lo));
  seg_scr_fold #(.N(N_HI), .P_W(P_W)) u_fold_hi (.prod(m_prod), .res(res_hi));

  always_comb begin
    if (m_tag == seg_scr_pkg::SEG_LARGE) vsid_d = N_LO'(res_hi);
    else                                 vsid_d = res_lo;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid_q <= 1'b0;
      out_vsid_q  <= '0;
      out_tag_q   <= seg_scr_pkg::SEG_SMALL;
    end else begin
      out_valid_q <= m_v;
      if (m_v) begin
        out_vsid_q <= vsid_d;
        out_tag_q  <= m_tag;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_vsid  = out_vsid_q;

  // checker: cycles since reset release, saturating at the latency
  logic [2:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)              since_rst_q <= '0;
    else if (since_rst_q != LAT) since_rst_q <= since_rst_q + 3'd1;
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    (since_rst_q == LAT) |-> out_valid_q == $past(in_valid, 4))
    else $error("result strobe not four cycles after request");

  a_r7_bad_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (since_rst_q == LAT && out_valid_q && $past(dec_bad, 4)) |-> out_vsid_q == '0)
    else $error("rejected request gave nonzero identifier");

  a_r4_no_modulus: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid_q && out_tag_q == seg_scr_pkg::SEG_SMALL) |-> out_vsid_q != '1)
    else $error("small-segment result equals modulus");

  a_r3_large_range: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid_q && out_tag_q == seg_scr_pkg::SEG_LARGE) |->
      (out_vsid_q[N_LO-1:N_HI] == '0 && out_vsid_q[N_HI-1:0] != '1))
    else $error("large-segment result out of range");

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid_q |-> $stable(out_vsid_q))
    else $error("identifier changed without strobe");
endmodule

// File: tb/tb_seg_id_scrambler.sv
module tb_seg_id_scrambler;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_kernel;
  logic        in_seg1t;
  logic [18:0] in_context;
  logic [63:0] in_ea;
  logic        out_valid;
  logic [36:0] out_vsid;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  logic [36:0] eq[$];
  int          cq[$];
  string       tq[$];
  logic [36:0] last_out = '0;
  bit          have_last = 0;

  seg_id_scrambler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kernel(in_kernel),
    .in_seg1t(in_seg1t), .in_context(in_context), .in_ea(in_ea),
    .out_valid(out_valid), .out_vsid(out_vsid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [36:0] ref_vsid(bit k, bit s, logic [18:0] c, logic [63:0] ea);
    logic [3:0]        nib;
    logic [18:0]       ctx;
    longint unsigned   proto;
    longint unsigned   m;
    nib = ea[63:60];
    if (ea[59:46] != 14'd0) return '0;
    if (k) begin
      if (nib < 4'hC) return '0;
      ctx = 19'h7FFFC + 19'(nib - 4'hC);
    end else begin
      if (c > 19'h7FFFB) return '0;
      ctx = c;
    end
    if (s) begin
      proto = 64'({ctx, ea[45:40]});
      m     = 64'h1FF_FFFF;
    end else begin
      proto = 64'({ctx, ea[45:28]});
      m     = 64'h1F_FFFF_FFFF;
    end
    return 37'((proto * 64'd12538073) % m);
  endfunction

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic monitor();
    logic [36:0] e;
    int          c;
    string       t;
    if (out_valid) begin
      if (eq.size() == 0) begin
        chk(1'b0, "R1 unexpected strobe", 64'(out_vsid), 0);
      end else begin
        e = eq.pop_front();
        c = cq.pop_front();
        t = tq.pop_front();
        chk(out_vsid == e, t, 64'(out_vsid), 64'(e));
        chk(cyc == c + 4, "R1 latency", 64'(cyc), 64'(c + 4));
      end
      last_out  = out_vsid;
      have_last = 1;
    end else if (have_last) begin
      chk(out_vsid == last_out, "R10 hold", 64'(out_vsid), 64'(last_out));
    end
  endtask

  task automatic step(bit v, bit k, bit s, logic [18:0] c, logic [63:0] ea, string tag);
    @(negedge clk);
    monitor();
    in_valid   = v;
    in_kernel  = k;
    in_seg1t   = s;
    in_context = c;
    in_ea      = ea;
    if (v) begin
      eq.push_back(ref_vsid(k, s, c, ea));
      cq.push_back(cyc);
      tq.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 1'($urandom), 1'($urandom), 19'($urandom), {$urandom, $urandom}, "");
  endtask

  function automatic logic [63:0] rand_ea(bit stray);
    logic [13:0] mid;
    mid = stray ? 14'($urandom) : 14'd0;
    return {4'($urandom), mid, 14'($urandom), $urandom};
  endfunction

  initial begin
    in_valid = 0; in_kernel = 0; in_seg1t = 0; in_context = '0; in_ea = '0;
    rst_n = 0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 0);
    chk(out_vsid == '0, "R9 reset value", 64'(out_vsid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && out_vsid == '0, "R9 after release", 64'(out_vsid), 0);
    repeat (3) @(negedge clk);

    // R2: small segments, directed
    step(1, 0, 0, 19'h0, 64'h0000_0000_1000_0000, "R2 ctx0 esid1");
    step(1, 0, 0, 19'h12345, 64'h0000_2ABC_D000_0000, "R2 mid ctx");
    step(1, 0, 0, 19'h7FFFB, 64'h0000_3FFF_F000_0000, "R2 max user ctx");
    // R3: large segments, directed
    step(1, 0, 1, 19'h00001, 64'h0000_0100_0000_0000, "R3 esid1");
    step(1, 0, 1, 19'h7FFFB, 64'h0000_3F00_0000_0000, "R3 max user ctx");
    // R4: all-ones proto in both sizes via the last kernel region
    step(1, 1, 0, 19'h0, 64'hF000_3FFF_F000_0000, "R4 small all ones");
    step(1, 1, 1, 19'h0, 64'hF000_3F00_0000_0000, "R4 large all ones");
    idle(2);
    // R5: kernel regions, context input varied
    step(1, 1, 0, 19'h1234, 64'hC000_0123_4000_0000, "R5 region C");
    step(1, 1, 0, 19'h7FFFF, 64'hD000_0123_4000_0000, "R5 region D");
    step(1, 1, 1, 19'h55555, 64'hE000_2A00_0000_0000, "R5 region E");
    step(1, 1, 0, 19'h00000, 64'hC000_0123_4000_0000, "R5 ctx ignored");
    // R6: kernel outside kernel regions
    step(1, 1, 0, 19'h1, 64'h5000_0000_1000_0000, "R6 region 5");
    step(1, 1, 1, 19'h1, 64'hB000_0100_0000_0000, "R6 region B");
    // R7: span limit
    step(1, 0, 0, 19'h5, 64'h0000_4000_1000_0000, "R7 bit46 small");
    step(1, 0, 1, 19'h5, 64'h0800_0000_0000_0000, "R7 bit59 large");
    step(1, 1, 0, 19'h5, 64'hC000_4000_1000_0000, "R7 bit46 kernel");
    // R8: user context limit and ignored top nibble
    step(1, 0, 0, 19'h7FFFC, 64'h0000_0000_1000_0000, "R8 ctx over limit");
    step(1, 0, 1, 19'h7FFFF, 64'h0000_0100_0000_0000, "R8 ctx max");
    step(1, 0, 0, 19'h00777, 64'hA000_0ABC_D000_0000, "R8 nibble A");
    step(1, 0, 0, 19'h00777, 64'h0000_0ABC_D000_0000, "R8 nibble 0");
    idle(6);

    // random mix with bubbles
    for (int i = 0; i < 400; i++) begin
      bit k;
      bit s;
      logic [18:0] c;
      logic [63:0] ea;
      k  = ($urandom % 4) == 0;
      s  = 1'($urandom);
      c  = 19'($urandom);
      ea = rand_ea(($urandom % 8) == 0);
      if (k) ea[63:62] = 2'b11;
      else   ea[63:60] = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      step(1, k, s, c, ea, k ? "R5 random kernel" : (s ? "R3 random" : "R2 random"));
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    idle(8);
    chk(eq.size() == 0, "R1 all results returned", 64'(eq.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule